// File: doc/BRIEF.md
# Plug-and-Play Card Control State Machine

This block is the card-side controller of a plug-and-play expansion card on a simple I/O bus. It watches a shared address port (0x279), where software writes a register index, and a shared write-data port (0xA79), where it writes the value for that index. It also watches a read-data port that software can move. It keeps the card's state, which is one of Wait for Key, Sleep, Isolation or Config. It also keeps the card select number (CSN), the selected logical device and the read-port location, and it carries out the global control commands.

Bus accesses are single-cycle strobes. A write or read is taken in the cycle its strobe is high, and the bus is never stalled. The one data stream leaving the block is the read response, `rd_valid` with `rd_data`. It has no ready input: the bus master must take the byte in the cycle `rd_valid` is high, so back-pressure cannot be applied. The power-on initiation key is a fixed byte sequence written to the address port. The serial-identification bit comparison and the per-device resource registers sit outside this block. This block reaches them only through one-cycle request pulses.

Top module: `pnp_card_ctrl`

## Requirements
- R1: After reset, `card_state` is Wait for Key (encoding 0 = Wait for Key, 1 = Sleep, 2 = Isolation, 3 = Config), `csn`, `ldn` and `rdport` are 0, and no pulse output or `rd_valid` is high.
- R2: In Wait for Key, the card moves to Sleep on the clock edge that takes the last byte of a 32-byte key written to address 0x279. The key starts at 0x6A, and each following byte is {b[0]^b[1], b[7:1]} of the byte before it. A byte that does not match restarts matching, and if that byte equals 0x6A it counts as the first key byte.
- R3: In Wait for Key, writes to 0xA79 change nothing (`csn`, `ldn`, `rdport`, state and pulses), and reads at the read port give no `rd_valid`.
- R4: Each write to 0x279 sets the register index. Outside Wait for Key, a write to 0xA79 acts on that index. A write to index 0x00 loads `rdport`, and the read port then answers at 12-bit address {2'b00, rdport, 2'b11}.
- R5: A write to index 0x02 has three independent effects. Bit 2 clears the CSN. Bit 1 returns the card to Wait for Key with the CSN kept. Bit 0 gives a one-cycle `ldev_reset` pulse with the CSN and state kept. Nothing stays set after the cycle of the write, and a read of index 0x02 returns 0x00.
- R6: A write to index 0x03 (Wake) in Sleep with data equal to the CSN moves the card to Isolation if the data is 0, or to Config otherwise. Wake in any other state, or with data that does not match, leaves the state unchanged.
- R7: Every Wake write outside Wait for Key gives a one-cycle `res_ptr_clr` pulse, whether the data matches or not.
- R8: A write to index 0x06 sets the CSN, and a read of index 0x06 returns it.
- R9: With more than one logical device, a write to index 0x07 of a value below the device count selects that device, and a larger value is ignored. A read of 0x07 returns the selection. A single-device card always reports 0.
- R10: A read of index 0x01 in Isolation gives a one-cycle `id_bit_req` pulse. In any other state the same read gives none. Reads of indexes other than 0x06 and 0x07 return 0x00.
- R11: A read at the read port outside Wait for Key makes `rd_valid` high for exactly the one cycle after the strobe, with `rd_data` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | I/O address of the current access |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| rd_valid | output | 1 | Read response valid, no ready |
| rd_data | output | 8 | Read response byte |
| card_state | output | 2 | Card state (0 key wait, 1 sleep, 2 isolation, 3 config) |
| csn | output | 8 | Card select number |
| ldn | output | 8 | Selected logical device |
| rdport | output | 8 | Read-port address bits [9:2] |
| ldev_reset | output | 1 | One-cycle reset request to logical devices |
| res_ptr_clr | output | 1 | One-cycle reset of the resource-data pointer |
| id_bit_req | output | 1 | One-cycle request to compare one ID bit |

## Verification
Every result of a strobe appears one clock edge after the edge that samples it. This covers the state, CSN, device select and read-port registers, the three command pulses, and the read response pair. The bench drives each strobe on a falling edge and compares all outputs at the next falling edge, after exactly one rising edge. An idle cycle that follows a command then shows that its pulse has cleared. A bench model of the registers predicts each expected value, including the values in a long random mix of index, data and read accesses.

// File: rtl/pnp_pkg.sv
package pnp_pkg;
  typedef enum logic [1:0] {
    ST_WAIT_KEY = 2'd0,
    ST_SLEEP    = 2'd1,
    ST_ISOLATE  = 2'd2,
    ST_CONFIG   = 2'd3
  } card_st_t;

  localparam logic [7:0] IX_RDPORT = 8'h00;
  localparam logic [7:0] IX_ISOL   = 8'h01;
  localparam logic [7:0] IX_CTRL   = 8'h02;
  localparam logic [7:0] IX_WAKE   = 8'h03;
  localparam logic [7:0] IX_CSN    = 8'h06;
  localparam logic [7:0] IX_LDN    = 8'h07;
endpackage

// File: rtl/pnp_bus_decode.sv
module pnp_bus_decode #(
  parameter int          ADDR_W     = 12,
  parameter logic [11:0] ADDR_PORT  = 12'h279,
  parameter logic [11:0] WDATA_PORT = 12'hA79
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        rdport,
  output logic              addr_wr,
  output logic              data_wr,
  output logic              port_rd
);
  localparam int PAD_W = ADDR_W - 10;

  logic [ADDR_W-1:0] rd_addr;
  assign rd_addr = {{PAD_W{1'b0}}, rdport, 2'b11};

  assign addr_wr = bus_wr && (bus_addr == ADDR_W'(ADDR_PORT));
  assign data_wr = bus_wr && (bus_addr == ADDR_W'(WDATA_PORT));
  assign port_rd = bus_rd && !bus_wr && (bus_addr == rd_addr);
endmodule

// File: rtl/pnp_key_match.sv
module pnp_key_match #(
  parameter int         KEY_LEN  = 32,
  parameter logic [7:0] KEY_SEED = 8'h6A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       byte_wr,
  input  logic [7:0] byte_in,
  output logic       key_done
);
  localparam int CNT_W = $clog2(KEY_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(KEY_LEN - 1);

  function automatic logic [7:0] step(input logic [7:0] b);
    return {b[0] ^ b[1], b[7:1]};
  endfunction

  logic [7:0]       exp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  assign hit      = (byte_in == exp_q);
  assign key_done = enable && byte_wr && hit && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= KEY_SEED;
      cnt_q <= '0;
    end else if (!enable || key_done) begin
      exp_q <= KEY_SEED;
      cnt_q <= '0;
    end else if (byte_wr) begin
      if (hit) begin
        exp_q <= step(exp_q);
        cnt_q <= cnt_q + 1'b1;
      end else if (byte_in == KEY_SEED) begin
        exp_q <= step(KEY_SEED);
        cnt_q <= CNT_W'(1);
      end else begin
        exp_q <= KEY_SEED;
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/pnp_card_regs.sv
module pnp_card_regs
  import pnp_pkg::*;
#(
  parameter int NUM_LDEV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_wr,
  input  logic       data_wr,
  input  logic       port_rd,
  input  logic       key_done,
  input  logic [7:0] wdata,
  output card_st_t   state,
  output logic [7:0] csn,
  output logic [7:0] ldn,
  output logic [7:0] rdport,
  output logic [7:0] idx,
  output logic       ldev_reset,
  output logic       res_ptr_clr,
  output logic       id_bit_req
);
  localparam int         LDN_W    = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1;
  localparam logic [8:0] LDEV_LIM = 9'(NUM_LDEV);

  logic     awake, wr_hit, is_ctrl, is_wake;
  card_st_t state_d;

  assign awake   = (state != ST_WAIT_KEY);
  assign wr_hit  = data_wr && awake;
  assign is_ctrl = wr_hit && (idx == IX_CTRL);
  assign is_wake = wr_hit && (idx == IX_WAKE);

  always_comb begin
    state_d = state;
    case (state)
      ST_WAIT_KEY: if (key_done) state_d = ST_SLEEP;
      ST_SLEEP:    if (is_wake && (wdata == csn))
                     state_d = (wdata == 8'h00) ? ST_ISOLATE : ST_CONFIG;
      default:     state_d = state;
    endcase
    if (is_ctrl && wdata[1]) state_d = ST_WAIT_KEY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_WAIT_KEY;
      idx         <= '0;
      csn         <= '0;
      rdport      <= '0;
      ldev_reset  <= 1'b0;
      res_ptr_clr <= 1'b0;
      id_bit_req  <= 1'b0;
    end else begin
      state       <= state_d;
      ldev_reset  <= is_ctrl && wdata[0];
      res_ptr_clr <= is_wake;
      id_bit_req  <= port_rd && (state == ST_ISOLATE) && (idx == IX_ISOL);
      if (addr_wr) idx <= wdata;
      if (wr_hit && (idx == IX_RDPORT)) rdport <= wdata;
      if (is_ctrl && wdata[2]) csn <= '0;
      else if (wr_hit && (idx == IX_CSN)) csn <= wdata;
    end
  end

  generate
    if (NUM_LDEV > 1) begin : g_multi
      logic [LDN_W-1:0] ldn_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ldn_q <= '0;
        else if (wr_hit && (idx == IX_LDN) && ({1'b0, wdata} < LDEV_LIM))
          ldn_q <= wdata[LDN_W-1:0];
      end
      assign ldn = 8'(ldn_q);
    end else begin : g_single
      assign ldn = 8'h00;
    end
  endgenerate
endmodule

// File: rtl/pnp_readback.sv
module pnp_readback
  import pnp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       port_rd,
  input  logic       awake,
  input  logic [7:0] idx,
  input  logic [7:0] csn,
  input  logic [7:0] ldn,
  output logic       rd_valid,
  output logic [7:0] rd_data
);
  logic [7:0] sel;
  logic       take;

  assign take = port_rd && awake;

  always_comb begin
    case (idx)
      IX_CSN:  sel = csn;
      IX_LDN:  sel = ldn;
      default: sel = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= take;
      if (take) rd_data <= sel;
    end
  end
endmodule

// File: rtl/pnp_card_ctrl.sv
module pnp_card_ctrl
  import pnp_pkg::*;
#(
  parameter int NUM_LDEV = 4,
  parameter int KEY_LEN  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] bus_addr,
  input  logic [7:0]  bus_wdata,
  input  logic        bus_wr,
  input  logic        bus_rd,
  output logic        rd_valid,
  output logic [7:0]  rd_data,
  output logic [1:0]  card_state,
  output logic [7:0]  csn,
  output logic [7:0]  ldn,
  output logic [7:0]  rdport,
  output logic        ldev_reset,
  output logic        res_ptr_clr,
  output logic        id_bit_req
);
  logic       addr_wr, data_wr, port_rd, key_done;
  logic [7:0] idx;
  card_st_t   state;

  assign card_state = state;

  pnp_bus_decode #(.ADDR_W(12)) u_dec (
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .rdport(rdport),
    .addr_wr(addr_wr), .data_wr(data_wr), .port_rd(port_rd)
  );

  pnp_key_match #(.KEY_LEN(KEY_LEN), .KEY_SEED(8'h6A)) u_key (
    .clk(clk), .rst_n(rst_n), .enable(state == ST_WAIT_KEY),
    .byte_wr(addr_wr), .byte_in(bus_wdata), .key_done(key_done)
  );

  pnp_card_regs #(.NUM_LDEV(NUM_LDEV)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .data_wr(data_wr),
    .port_rd(port_rd), .key_done(key_done), .wdata(bus_wdata),
    .state(state), .csn(csn), .ldn(ldn), .rdport(rdport), .idx(idx),
    .ldev_reset(ldev_reset), .res_ptr_clr(res_ptr_clr), .id_bit_req(id_bit_req)
  );

  pnp_readback u_rb (
    .clk(clk), .rst_n(rst_n), .port_rd(port_rd), .awake(state != ST_WAIT_KEY),
    .idx(idx), .csn(csn), .ldn(ldn), .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/pnp_card_ctrl_chk.sv
module pnp_card_ctrl_chk #(
  parameter int NUM_LDEV = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_rd,
  input logic [7:0] bus_wdata,
  input logic       data_wr,
  input logic [7:0] idx,
  input logic [1:0] card_state,
  input logic [7:0] csn,
  input logic [7:0] ldn,
  input logic [7:0] rdport,
  input logic       rd_valid,
  input logic       ldev_reset
);
  p_key_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(card_state) == 2'd0 && card_state != 2'd0) |-> card_state == 2'd1);

  p_wfk_no_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (card_state == 2'd0 && bus_rd) |=> !rd_valid);

  p_wfk_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (card_state == 2'd0 && data_wr) |=> ($stable(csn) && $stable(rdport)));

  p_csn_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (card_state != 2'd0 && data_wr && idx == 8'h02 && bus_wdata[2]) |=> csn == 8'h00);

  p_ldev_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ldev_reset |-> $past(data_wr && idx == 8'h02 && bus_wdata[0] && card_state != 2'd0));

  p_wake_iso_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (card_state == 2'd1 && data_wr && idx == 8'h03 && bus_wdata == 8'h00 && csn == 8'h00)
      |=> card_state == 2'd2);

  p_ldn_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ldn) < ((NUM_LDEV > 1) ? NUM_LDEV : 1));

  p_rd_origin_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(bus_rd));
endmodule

bind pnp_card_ctrl pnp_card_ctrl_chk #(.NUM_LDEV(NUM_LDEV)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
  .data_wr(data_wr), .idx(idx), .card_state(card_state), .csn(csn),
  .ldn(ldn), .rdport(rdport), .rd_valid(rd_valid), .ldev_reset(ldev_reset)
);

// File: tb/pnp_card_ctrl_tb.sv
module pnp_card_ctrl_tb;
  localparam logic [11:0] A_PORT = 12'h279;
  localparam logic [11:0] D_PORT = 12'hA79;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic rd_valid, ldev_reset, res_ptr_clr, id_bit_req;
  logic [7:0] rd_data, csn, ldn, rdport;
  logic [1:0] card_state;
  logic rd_valid_s, ldev_reset_s, res_ptr_clr_s, id_bit_req_s;
  logic [7:0] rd_data_s, csn_s, ldn_s, rdport_s;
  logic [1:0] card_state_s;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  logic [1:0] m_state;
  logic [7:0] m_csn, m_ldn, m_rdport, m_idx, m_rd;
  logic m_ldrst, m_ptrclr, m_idreq, m_rv;

  always #2 clk = ~clk;

  pnp_card_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .rd_valid(rd_valid), .rd_data(rd_data),
    .card_state(card_state), .csn(csn), .ldn(ldn), .rdport(rdport),
    .ldev_reset(ldev_reset), .res_ptr_clr(res_ptr_clr), .id_bit_req(id_bit_req));

  pnp_card_ctrl #(.NUM_LDEV(1)) u_dut_single (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .rd_valid(rd_valid_s), .rd_data(rd_data_s),
    .card_state(card_state_s), .csn(csn_s), .ldn(ldn_s), .rdport(rdport_s),
    .ldev_reset(ldev_reset_s), .res_ptr_clr(res_ptr_clr_s), .id_bit_req(id_bit_req_s));

  function automatic logic [7:0] key_byte(input int i);
    logic [7:0] b = 8'h6A;
    for (int k = 0; k < i; k++) b = {b[0] ^ b[1], b[7:1]};
    return b;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "state", card_state, m_state);
    chk(req, "csn", csn, m_csn);
    chk(req, "ldn", ldn, m_ldn);
    chk(req, "rdport", rdport, m_rdport);
    chk(req, "ldev_reset", ldev_reset, m_ldrst);
    chk(req, "res_ptr_clr", res_ptr_clr, m_ptrclr);
    chk(req, "id_bit_req", id_bit_req, m_idreq);
    chk(req, "rd_valid", rd_valid, m_rv);
    if (m_rv) chk(req, "rd_data", rd_data, m_rd);
  endtask

  function automatic void clr_pulses();
    m_ldrst = 0; m_ptrclr = 0; m_idreq = 0; m_rv = 0;
  endfunction

  // Each op starts at a falling edge and returns at the next falling edge.
  task automatic idle();
    clr_pulses();
    @(negedge clk);
  endtask

  task automatic wr_index(input logic [7:0] b);
    clr_pulses();
    m_idx = b;
    bus_addr = A_PORT; bus_wdata = b; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic wr_data(input logic [7:0] d);
    clr_pulses();
    if (m_state != 2'd0) begin
      case (m_idx)
        8'h00: m_rdport = d;
        8'h02: begin
          m_ldrst = d[0];
          if (d[2]) m_csn = 8'h00;
          if (d[1]) m_state = 2'd0;
        end
        8'h03: begin
          m_ptrclr = 1;
          if (m_state == 2'd1 && d == m_csn) m_state = (d == 8'h00) ? 2'd2 : 2'd3;
        end
        8'h06: m_csn = d;
        8'h07: if (d < 8'd4) m_ldn = d;
        default: ;
      endcase
    end
    bus_addr = D_PORT; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd_port();
    clr_pulses();
    if (m_state != 2'd0) begin
      m_rv = 1;
      m_rd = (m_idx == 8'h06) ? m_csn : (m_idx == 8'h07) ? m_ldn : 8'h00;
      m_idreq = (m_state == 2'd2 && m_idx == 8'h01);
    end
    bus_addr = {2'b00, m_rdport, 2'b11}; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic send_key();
    for (int i = 0; i < 32; i++) wr_index(key_byte(i));
    m_state = 2'd1;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_state = 0; m_csn = 0; m_ldn = 0; m_rdport = 0; m_idx = 0; m_rd = 0;
    clr_pulses();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_all("R1");

    // R3: Wait for Key ignores data writes and reads
    wr_index(8'h06); wr_data(8'h55); chk_all("R3");
    rd_port(); chk_all("R3");

    // R2: broken key stays in Wait for Key
    for (int i = 0; i < 10; i++) wr_index(key_byte(i));
    wr_index(8'h00);
    for (int i = 10; i < 32; i++) wr_index(key_byte(i));
    chk_all("R2");
    // R2: mismatching byte equal to first key byte restarts at one
    for (int i = 0; i < 5; i++) wr_index(key_byte(i));
    wr_index(8'h6A);
    for (int i = 1; i < 32; i++) wr_index(key_byte(i));
    m_state = 2'd1;
    chk_all("R2");

    // R4: move the read port, read CSN through it (R8, R11)
    wr_index(8'h00); wr_data(8'h9E); chk_all("R4");
    wr_index(8'h06); rd_port(); chk_all("R11");
    idle(); chk_all("R11");

    // R6/R7: mismatched wake, then wake with 0
    wr_index(8'h03); wr_data(8'h05); chk_all("R7");
    wr_data(8'h00); chk_all("R6");
    wr_index(8'h01); rd_port(); chk_all("R10");

    // R8: set CSN, read back
    wr_index(8'h06); wr_data(8'h05); rd_port(); chk_all("R8");
    // R5: bit1 returns to key wait keeping CSN
    wr_index(8'h02); wr_data(8'h02); chk_all("R5");
    send_key(); chk_all("R2");
    wr_index(8'h03); wr_data(8'h05); chk_all("R6");
    wr_data(8'h00); chk_all("R6");
    wr_index(8'h01); rd_port(); chk_all("R10");

    // R9: device select, range and single-device card
    wr_index(8'h07); wr_data(8'h03); chk_all("R9");
    wr_data(8'h09); chk_all("R9");
    rd_port(); chk_all("R9");
    chk("R9", "single ldn", ldn_s, 0);
    chk("R9", "single rd_data", rd_data_s, 0);

    // R5: bit0 pulse, not sticky; read of index 2 is zero
    wr_index(8'h02); wr_data(8'h01); chk_all("R5");
    idle(); chk_all("R5");
    rd_port(); chk_all("R5");
    wr_data(8'h04); chk_all("R5");
    wr_data(8'h07); chk_all("R5");
    send_key();

    // Random mix
    for (int n = 0; n < 600; n++) begin
      int r;
      logic [7:0] d;
      if (m_state == 2'd0) send_key();
      r = $urandom % 8;
      if (r < 2) begin
        case ($urandom % 7)
          0: d = 8'h00; 1: d = 8'h01; 2: d = 8'h02; 3: d = 8'h03;
          4: d = 8'h06; 5: d = 8'h07; default: d = 8'($urandom);
        endcase
        wr_index(d);
      end else if (r < 5) begin
        d = 8'($urandom);
        if (m_idx == 8'h03 && ($urandom % 2) == 0) d = m_csn;
        if (m_idx == 8'h02) d = d & ((($urandom % 4) == 0) ? 8'h07 : 8'h05);
        if (m_idx == 8'h06 && ($urandom % 3) == 0) d = 8'h00;
        wr_data(d);
      end else if (r < 7) begin
        rd_port();
      end else begin
        idle();
      end
      chk_all("R4");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule